// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the most recent resolved branch outcomes. That record is joined with a few low-order bits of the branch address to select one 2-bit saturating counter. The history bits therefore choose one of 2^HIST_W counter banks, and the address bits choose an entry inside that bank. The most significant bit of the selected counter is the prediction.

The fetch side presents a PC on the lookup port and reads the direction combinationally in the same cycle. When a branch resolves, the back end presents its PC and real outcome on the update port. At the next clock edge the counter used for that branch is trained, and the outcome is shifted into the history. Entries carry no address tag, so branches whose index bits match share counters. With HIST_W set to 0 the block becomes a plain table of 2-bit counters indexed by address alone.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the history is all zeros, so every lookup PC predicts not taken.
- R2: The lookup output is bit 1 of the counter at index {history, pc[PC_LSB+IDX_W-1:PC_LSB]}. History occupies the upper index bits, and history bit 0 is the most recent outcome. The output is combinational from the lookup PC.
- R3: An update with outcome taken adds one to the selected counter, and the counter saturates at 3.
- R4: An update with outcome not taken subtracts one from the selected counter, and the counter saturates at 0.
- R5: A counter at 3 that receives one not-taken update still predicts taken. The prediction flips only after a second not-taken update.
- R6: An update selects its counter with the history value held before the edge. At the same edge the history shifts left by one and the new outcome enters bit 0.
- R7: An update changes only the selected counter. Counters for the same PC under other history values, and counters for other PCs, are left unchanged.
- R8: There is no tag check. Two PCs that differ only above bit PC_LSB+IDX_W-1 read and train the same counters.
- R9: With HIST_W = 0 the index is the address bits alone, and the block acts as a single table of 2-bit counters.
- R10: While up_valid_i is low, up_pc_i and up_taken_i have no effect on any counter or on the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | PC of the branch being predicted |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_pc_i | input | PC_W | PC of the resolved branch |
| up_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest situation to reach is a test of one particular counter under one particular history value. Every update also moves the history, so training a counter immediately moves the block's view away from that counter. The stimulus therefore steers the history back by sending updates from an unrelated PC with chosen outcomes. It then looks up the trained PC again. This is how the hysteresis case, the old-history rule and the isolation between banks are reached. A behavioural model built from the requirements tracks every counter. After each phase, sweeps over all address indices compare both a correlating instance and a history-free instance against that model.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  function automatic ctr_t ctr_next(ctr_t cur, logic taken);
    if (taken) return (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       return (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
  endfunction
endpackage

// File: rtl/corr_bp_history.sv
module corr_bp_history #(
  parameter int HIST_W = 2,
  parameter int HW_EFF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HW_EFF-1:0] hist_o
);
  if (HIST_W > 0) begin : g_hist
    logic [HW_EFF-1:0] hist_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q <= '0;
      else if (shift_i) hist_q <= HW_EFF'({hist_q, taken_i});
    end
    assign hist_o = hist_q;

    AST_HIST_NEWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> hist_q[0] == $past(taken_i));  // R6
    AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(hist_q));  // R10
  end else begin : g_no_hist
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, shift_i, taken_i};
    assign hist_o = '0;
  end
endmodule

// File: rtl/corr_bp_index.sv
module corr_bp_index #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int HW_EFF = 2,
  parameter int TBL_W  = 6
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HW_EFF-1:0] hist_i,
  output logic [TBL_W-1:0]  idx_o
);
  logic unused_pc;
  assign unused_pc = ^pc_i;

  if (HIST_W > 0) begin : g_corr
    assign idx_o = {hist_i, pc_i[PC_LSB +: IDX_W]};
  end else begin : g_flat
    logic unused_hist;
    assign unused_hist = ^hist_i;
    assign idx_o = pc_i[PC_LSB +: IDX_W];
  end
endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table
  import corr_bp_pkg::*;
#(
  parameter int TBL_W = 6,
  parameter int DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TBL_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [TBL_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  output ctr_t             wr_cur_o
);
  ctr_t cnt_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      cnt_q[wr_idx_i] <= ctr_next(cnt_q[wr_idx_i], wr_taken_i);
    end
  end

  assign rd_ctr_o = cnt_q[rd_idx_i];
  assign wr_cur_o = cnt_q[wr_idx_i];

  AST_CTR_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_taken_i && wr_cur_o != CTR_MAX)
      |=> cnt_q[$past(wr_idx_i)] == $past(wr_cur_o) + 2'd1);  // R3
  AST_CTR_SAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_taken_i && wr_cur_o == CTR_MAX)
      |=> cnt_q[$past(wr_idx_i)] == CTR_MAX);  // R3
  AST_CTR_STEP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_taken_i && wr_cur_o != CTR_MIN)
      |=> cnt_q[$past(wr_idx_i)] == $past(wr_cur_o) - 2'd1);  // R4
  AST_CTR_SAT_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_taken_i && wr_cur_o == CTR_MIN)
      |=> cnt_q[$past(wr_idx_i)] == CTR_MIN);  // R4
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import corr_bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_taken_i
);
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1;
  localparam int TBL_W  = IDX_W + HIST_W;
  localparam int DEPTH  = 1 << TBL_W;

  logic [HW_EFF-1:0] hist;
  logic [TBL_W-1:0]  lk_idx, up_idx;
  ctr_t              lk_ctr, up_cur;

  corr_bp_history #(.HIST_W(HIST_W), .HW_EFF(HW_EFF)) u_hist (
    .clk_i, .rst_ni,
    .shift_i (up_valid_i),
    .taken_i (up_taken_i),
    .hist_o  (hist)
  );

  corr_bp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W),
                  .HIST_W(HIST_W), .HW_EFF(HW_EFF), .TBL_W(TBL_W)) u_lk_idx (
    .pc_i (lk_pc_i), .hist_i (hist), .idx_o (lk_idx)
  );

  // update indexes with pre-shift history
  corr_bp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W),
                  .HIST_W(HIST_W), .HW_EFF(HW_EFF), .TBL_W(TBL_W)) u_up_idx (
    .pc_i (up_pc_i), .hist_i (hist), .idx_o (up_idx)
  );

  corr_bp_table #(.TBL_W(TBL_W), .DEPTH(DEPTH)) u_tbl (
    .clk_i, .rst_ni,
    .rd_idx_i   (lk_idx),
    .rd_ctr_o   (lk_ctr),
    .wr_en_i    (up_valid_i),
    .wr_idx_i   (up_idx),
    .wr_taken_i (up_taken_i),
    .wr_cur_o   (up_cur)
  );

  logic unused_cur;
  assign unused_cur = ^up_cur;

  assign lk_taken_o = lk_ctr[1];

  AST_SAME_PC_SAME_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_pc_i == up_pc_i) |-> (lk_taken_o == up_cur[1]));  // R2
endmodule

// File: tb/corr_branch_predictor_bench.sv
module corr_branch_predictor_bench;
  localparam int CLK_P  = 10;
  localparam int PC_W   = 32;
  localparam int PC_LSB = 2;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 2;
  localparam int NPC    = 1 << IDX_W;
  localparam int NENT   = NPC << HIST_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 0, up_taken = 0;
  logic lk_taken, lk_taken_f;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt [NENT];
  int m_flat [NPC];
  int m_hist;

  always #(CLK_P/2) clk = ~clk;

  corr_branch_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W))
  u_corr_branch_predictor (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(lk_taken),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken));

  corr_branch_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(0))
  u_corr_branch_predictor_flat (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(lk_taken_f),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken));

  function automatic int pc_bits(logic [PC_W-1:0] pc);
    return int'((pc >> PC_LSB) & (NPC - 1));
  endfunction

  function automatic int sat(int c, logic t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic expect_bit(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pc=%h actual=%0b expected=%0b", req, lk_pc, act, exp);
    end
  endtask

  task automatic chk(logic [PC_W-1:0] pc, string req);
    @(negedge clk);
    lk_pc = pc;
    #1;
    expect_bit(lk_taken, m_cnt[(m_hist << IDX_W) | pc_bits(pc)] >= 2, req);
    expect_bit(lk_taken_f, m_flat[pc_bits(pc)] >= 2, "R9");
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NPC; i++) chk(PC_W'(i << PC_LSB), req);
  endtask

  task automatic upd(logic [PC_W-1:0] pc, logic t);
    int mi;
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = t;
    @(negedge clk);
    up_valid = 0;
    mi = (m_hist << IDX_W) | pc_bits(pc);
    m_cnt[mi] = sat(m_cnt[mi], t);
    m_flat[pc_bits(pc)] = sat(m_flat[pc_bits(pc)], t);
    m_hist = ((m_hist << 1) | int'(t)) & ((1 << HIST_W) - 1);
  endtask

  localparam logic [PC_W-1:0] PC_A = 32'h0000_0014;
  localparam logic [PC_W-1:0] PC_B = 32'h0000_0028;
  localparam logic [PC_W-1:0] PC_C = 32'h0000_0030;

  task automatic t_reset;
    sweep("R1");
    expect_bit(lk_taken, 1'b0, "R1");
  endtask

  task automatic t_saturate_up;
    for (int i = 0; i < 5; i++) upd(PC_A, 1'b1);
    chk(PC_A, "R3");
    expect_bit(lk_taken, 1'b1, "R3");
    sweep("R7");
  endtask

  task automatic t_hysteresis;
    upd(PC_A, 1'b0);            // table 11 counter 3 -> 2
    upd(PC_B, 1'b1);
    upd(PC_B, 1'b1);            // history back to 11
    chk(PC_A, "R5");
    expect_bit(lk_taken, 1'b1, "R5");
    upd(PC_A, 1'b0);            // 2 -> 1
    upd(PC_B, 1'b1);
    upd(PC_B, 1'b1);
    chk(PC_A, "R5");
    expect_bit(lk_taken, 1'b0, "R5");
  endtask

  task automatic t_saturate_down;
    for (int i = 0; i < 6; i++) upd(PC_A, 1'b0);
    upd(PC_A, 1'b1);            // from floor 0 to 1, still not taken
    upd(PC_B, 1'b0);
    upd(PC_B, 1'b0);
    chk(PC_A, "R4");
    expect_bit(lk_taken, 1'b0, "R4");
    sweep("R4");
  endtask

  task automatic t_old_history;
    upd(PC_B, 1'b0);
    upd(PC_B, 1'b0);            // history 00
    upd(PC_C, 1'b1);            // trains bank 00, history -> 01
    chk(PC_C, "R6");
    expect_bit(lk_taken, 1'b0, "R6");
    upd(PC_B, 1'b0);
    upd(PC_B, 1'b0);
    chk(PC_C, "R6");
    expect_bit(lk_taken, 1'b1, "R6");
    sweep("R2");
  endtask

  task automatic t_alias;
    upd(PC_A | (PC_W'(1) << (PC_LSB + IDX_W + 3)), 1'b1);
    upd(PC_B, 1'b0);
    upd(PC_B, 1'b0);
    chk(PC_A | (PC_W'(5) << (PC_LSB + IDX_W)), "R8");
    chk(PC_A, "R8");
    sweep("R8");
  endtask

  task automatic t_idle;
    @(negedge clk);
    up_valid = 0; up_pc = PC_C; up_taken = 1;
    repeat (6) @(negedge clk);
    up_taken = 0; up_pc = PC_A;
    repeat (6) @(negedge clk);
    sweep("R10");
  endtask

  task automatic t_pattern;
    for (int i = 0; i < 40; i++) begin
      logic [PC_W-1:0] p;
      p = PC_W'(((i * 7) % NPC) << PC_LSB);
      upd(p, (i % 3) != 0);
      chk(p, "R2");
    end
    sweep("R7");
  endtask

  initial begin
    for (int i = 0; i < NENT; i++) m_cnt[i] = 1;
    for (int i = 0; i < NPC; i++) m_flat[i] = 1;
    m_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_saturate_up();
    t_hysteresis();
    t_saturate_down();
    t_old_history();
    t_alias();
    t_idle();
    t_pattern();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule